// File: doc/BRIEF.md
# PLL multiplier code converter

This block translates a PLL feedback multiplier between its plain binary value and the scrambled 17-bit code that the PLL's multiplier register expects. The code for a multiplier is the state that a 15-bit shift-register sequence reaches after a number of steps that depends on the multiplier. Conversion is therefore done by stepping the sequence one position per clock rather than by arithmetic.

The encode side takes a binary multiplier and returns a full register word. That word carries the scrambled code together with two loop-bandwidth fields, the proportional and the integral selector, both derived from the binary multiplier. The decode side takes a code and returns the multiplier, or zero when the code is not reachable. Each side has a start pulse and a one-cycle done pulse. A conversion can take up to about 32 770 clocks, and only one conversion runs at a time.

Top module: `pll_mcode_conv`

## Requirements
- R1: Encoding multiplier 0 yields code 0x00000, multiplier 1 yields 0x18003 and multiplier 2 yields 0x10003.
- R2: For a multiplier m from 3 to 32768 the code is obtained by starting from 0x4000 and applying, 32769-m times, the step x <= {x[0]^x[1], x[14:1]} (a 15-bit value, upper code bits zero).
- R3: The proportional selector is (m>>1)+1 when m is below 60 and 31 otherwise.
- R4: The integral selector is 1 for m above 16384, 2 for m above 8192, 4 for m above 2048, 8 for m from 501 up, 4*ceil(1024/(m+9)) for m from 60 to 500, and (m & 0x3C)+4 below 60.
- R5: The encode word places the code in bits 16:0, the proportional selector in bits 21:17 and the integral selector in bits 27:22; bits 31:28 are zero.
- R6: Decoding 0x18003 yields 1 and decoding 0x10003 yields 2.
- R7: For any other code a counter starts at 32769 and, while the value differs from 0x4000 and the counter is nonzero, the value steps as x <= {x[13:0], x[0]^x[14]} and the counter drops by one; the final counter is the result, so a decode of an encoded multiplier returns that multiplier.
- R8: A code that never reaches 0x4000 (for example 0) decodes to 0.
- R9: An encode start with a multiplier above 32768 raises the error output for exactly one cycle, starts nothing, produces no encode done and leaves the encode word unchanged.
- R10: Starts arriving while a conversion runs are ignored; when both starts arrive together while idle, the encode runs and the decode start is dropped.
- R11: After reset, both done outputs and the error output are low and both result outputs are zero.
- R12: Each done is a one-cycle pulse; a conversion needing s sequence steps raises done on the (s+1)-th clock after the clock that accepted the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encStart | input | 1 | Start an encode using encMult |
| encMult | input | 16 | Binary multiplier to encode |
| encDone | output | 1 | One-cycle pulse, encWord valid |
| encErr | output | 1 | One-cycle pulse, encode multiplier out of range |
| encWord | output | 32 | Packed multiplier register word |
| decStart | input | 1 | Start a decode using decCode |
| decCode | input | 17 | Scrambled code to decode |
| decDone | output | 1 | One-cycle pulse, decMult valid |
| decMult | output | 16 | Decoded multiplier, 0 for an invalid code |

## Verification
Encodes near the top of the range need only a few steps, so their codes are known by hand and pin down the step direction and the feedback taps; the same codes decoded back confirm that the two sequences are inverse and that the counter lands on the multiplier. Encodes at 20000, 12000, 3000, 119 and 40 each land in a different integral-selector band, and 119 makes m+9 divide 1024 exactly, which separates a correct ceiling from an off-by-one quotient. The special codes, the all-zero code, an out-of-range multiplier and starts overlapping a running conversion tell the shortcut paths and the arbitration apart from the stepping path.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic encLoad;
    logic encStep;
    logic encFin;
    logic encErr;
    logic decLoad;
    logic decStep;
    logic decFin;
  } mcode_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ENC  = 2'd1,
    ST_DEC  = 2'd2
  } mcode_state_t;

  // bandwidth selector thresholds
  localparam int unsigned BW_ABOVE_1  = 16384;
  localparam int unsigned BW_ABOVE_2  = 8192;
  localparam int unsigned BW_ABOVE_4  = 2048;
  localparam int unsigned BW_FROM_8   = 501;
  localparam int unsigned BW_DIV_LO   = 60;
  localparam int unsigned BW_DIV_HI   = 500;
  localparam int unsigned BW_DIV_NUM  = 1024;
  localparam int unsigned BW_DIV_OFS  = 9;
  localparam int unsigned SELP_W      = 5;
  localparam int unsigned SELI_W      = 6;

endpackage

// File: rtl/pll_mcode_ctrl.sv
module pll_mcode_ctrl
  import pll_mcode_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          encStart,
  input  logic          decStart,
  input  logic          encOver,
  input  logic          encLast,
  input  logic          decLast,
  output mcode_strobe_t stb
);

  mcode_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (encStart) begin
          if (encOver) stb.encErr = 1'b1;
          else begin
            stb.encLoad = 1'b1;
            stateNext   = ST_ENC;
          end
        end else if (decStart) begin
          stb.decLoad = 1'b1;
          stateNext   = ST_DEC;
        end
      end
      ST_ENC: begin
        if (encLast) begin
          stb.encFin = 1'b1;
          stateNext  = ST_IDLE;
        end else stb.encStep = 1'b1;
      end
      ST_DEC: begin
        if (decLast) begin
          stb.decFin = 1'b1;
          stateNext  = ST_IDLE;
        end else stb.decStep = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pll_mcode_dp.sv
module pll_mcode_dp
  import pll_mcode_pkg::*;
#(
  parameter int unsigned LfsrW = 15,
  parameter int unsigned WordW = 32,
  localparam int unsigned MultW = LfsrW + 1,
  localparam int unsigned CodeW = LfsrW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MultW-1:0] encMult,
  input  logic [CodeW-1:0] decCode,
  input  mcode_strobe_t    stb,
  output logic             encOver,
  output logic             encLast,
  output logic             decLast,
  output logic             encDone,
  output logic             encErr,
  output logic [WordW-1:0] encWord,
  output logic             decDone,
  output logic [MultW-1:0] decMult
);

  localparam logic [MultW-1:0] MaxMult  = MultW'(1) << LfsrW;
  localparam logic [MultW-1:0] CntInit  = MaxMult + MultW'(1);
  localparam logic [CodeW-1:0] Seed     = CodeW'(1) << (LfsrW - 1);
  localparam logic [CodeW-1:0] CodeOne  = {2'b11, {(LfsrW-2){1'b0}}, 2'b11};
  localparam logic [CodeW-1:0] CodeTwo  = {2'b10, {(LfsrW-2){1'b0}}, 2'b11};
  localparam int unsigned      DivW     = $clog2(BW_DIV_NUM) + 1;
  localparam int unsigned      QuotW    = SELI_W - 2;
  localparam int unsigned      PadW     = WordW - CodeW - SELP_W - SELI_W;

  logic [CodeW-1:0]  xReg, encNext, decNext;
  logic [MultW-1:0]  cntReg, multReg;
  logic              divBusy;
  logic [DivW-1:0]   divRem, divSor;
  logic [QuotW-1:0]  quot;
  logic [SELP_W-1:0] selpVal;
  logic [SELI_W-1:0] seliVal;

  assign encOver = encMult > MaxMult;
  assign encLast = (cntReg == '0) && !divBusy;
  assign decLast = (xReg == Seed) || (cntReg == '0);

  // forward step moves right, reverse step moves left
  assign encNext = {2'b00, xReg[0] ^ xReg[1], xReg[LfsrW-1:1]};
  assign decNext = {2'b00, xReg[LfsrW-2:0], xReg[0] ^ xReg[LfsrW-1]};

  always_comb begin
    if (multReg < MultW'(BW_DIV_LO)) selpVal = multReg[SELP_W:1] + SELP_W'(1);
    else                             selpVal = '1;
  end

  always_comb begin
    if      (multReg >  MultW'(BW_ABOVE_1)) seliVal = SELI_W'(1);
    else if (multReg >  MultW'(BW_ABOVE_2)) seliVal = SELI_W'(2);
    else if (multReg >  MultW'(BW_ABOVE_4)) seliVal = SELI_W'(4);
    else if (multReg >= MultW'(BW_FROM_8))  seliVal = SELI_W'(8);
    else if (multReg >= MultW'(BW_DIV_LO))  seliVal = {quot, 2'b00};
    else seliVal = (multReg[SELI_W-1:0] & SELI_W'(8'h3C)) + SELI_W'(4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      cntReg  <= '0;
      multReg <= '0;
      divBusy <= 1'b0;
      divRem  <= '0;
      divSor  <= '0;
      quot    <= '0;
      encDone <= 1'b0;
      encErr  <= 1'b0;
      decDone <= 1'b0;
      encWord <= '0;
      decMult <= '0;
    end else begin
      encDone <= stb.encFin;
      encErr  <= stb.encErr;
      decDone <= stb.decFin;
      if (stb.encLoad) begin
        multReg <= encMult;
        divBusy <= (encMult >= MultW'(BW_DIV_LO)) && (encMult <= MultW'(BW_DIV_HI));
        divRem  <= DivW'(BW_DIV_NUM);
        divSor  <= DivW'(encMult) + DivW'(BW_DIV_OFS);
        quot    <= '0;
        if (encMult == MultW'(0)) begin
          xReg <= '0; cntReg <= '0;
        end else if (encMult == MultW'(1)) begin
          xReg <= CodeOne; cntReg <= '0;
        end else if (encMult == MultW'(2)) begin
          xReg <= CodeTwo; cntReg <= '0;
        end else begin
          xReg <= Seed; cntReg <= CntInit - encMult;
        end
      end
      if (stb.encStep) begin
        if (cntReg != '0) begin
          xReg   <= encNext;
          cntReg <= cntReg - MultW'(1);
        end
        if (divBusy) begin
          quot <= quot + QuotW'(1);
          if (divRem > divSor) divRem <= divRem - divSor;
          else                 divBusy <= 1'b0;
        end
      end
      if (stb.encFin) encWord <= {{PadW{1'b0}}, seliVal, selpVal, xReg};
      if (stb.decLoad) begin
        divBusy <= 1'b0;
        if (decCode == CodeOne) begin
          xReg <= Seed; cntReg <= MultW'(1);
        end else if (decCode == CodeTwo) begin
          xReg <= Seed; cntReg <= MultW'(2);
        end else begin
          xReg <= decCode; cntReg <= CntInit;
        end
      end
      if (stb.decStep) begin
        xReg   <= decNext;
        cntReg <= cntReg - MultW'(1);
      end
      if (stb.decFin) decMult <= cntReg;
    end
  end

endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pll_mcode_pkg::*;
#(
  parameter int unsigned LfsrW = 15,
  parameter int unsigned WordW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encStart,
  input  logic [LfsrW:0]   encMult,
  output logic             encDone,
  output logic             encErr,
  output logic [WordW-1:0] encWord,
  input  logic             decStart,
  input  logic [LfsrW+1:0] decCode,
  output logic             decDone,
  output logic [LfsrW:0]   decMult
);

  mcode_strobe_t stb;
  logic encOver, encLast, decLast;

  pll_mcode_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .encStart (encStart),
    .decStart (decStart),
    .encOver  (encOver),
    .encLast  (encLast),
    .decLast  (decLast),
    .stb      (stb)
  );

  pll_mcode_dp #(.LfsrW(LfsrW), .WordW(WordW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .encMult (encMult),
    .decCode (decCode),
    .stb     (stb),
    .encOver (encOver),
    .encLast (encLast),
    .decLast (decLast),
    .encDone (encDone),
    .encErr  (encErr),
    .encWord (encWord),
    .decDone (decDone),
    .decMult (decMult)
  );

endmodule

// File: rtl/pll_mcode_conv_chk.sv
module pll_mcode_conv_chk
  import pll_mcode_pkg::*;
#(
  parameter int unsigned LfsrW = 15,
  parameter int unsigned WordW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             encStart,
  input logic [LfsrW:0]   encMult,
  input logic             encDone,
  input logic             encErr,
  input logic [WordW-1:0] encWord,
  input logic             decDone,
  input logic [LfsrW:0]   decMult,
  input mcode_strobe_t    stb
);

  localparam logic [LfsrW:0] MaxMult = (LfsrW+1)'(1) << LfsrW;
  localparam int unsigned    SelpLsb = LfsrW + 2;
  localparam int unsigned    SeliLsb = SelpLsb + SELP_W;
  localparam int unsigned    PadLsb  = SeliLsb + SELI_W;

  logic busyChk;
  always_ff @(posedge clk) begin
    if (!rstN) busyChk <= 1'b0;
    else if (stb.encLoad || stb.decLoad) busyChk <= 1'b1;
    else if (stb.encFin || stb.decFin)   busyChk <= 1'b0;
  end

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    encErr |-> ($past(encStart) && ($past(encMult) > MaxMult)));

  // R9
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    encErr |-> !encDone);

  // R10
  busy_no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyChk |-> !(stb.encLoad || stb.decLoad));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(encDone && decDone));

  // R12
  enc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    encDone |=> !encDone);

  // R12
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decDone |=> !decDone);

  // R5
  word_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    encDone |-> ((encWord[WordW-1:PadLsb] == '0) &&
                 (encWord[SeliLsb-1:SelpLsb] != '0) &&
                 (encWord[PadLsb-1:SeliLsb] != '0)));

  // R8
  dec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    decDone |-> (decMult <= MaxMult + (LfsrW+1)'(1)));

endmodule

bind pll_mcode_conv pll_mcode_conv_chk #(.LfsrW(LfsrW), .WordW(WordW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .encStart (encStart),
  .encMult  (encMult),
  .encDone  (encDone),
  .encErr   (encErr),
  .encWord  (encWord),
  .decDone  (decDone),
  .decMult  (decMult),
  .stb      (stb)
);

// File: tb/pll_mcode_conv_test.sv
module pll_mcode_conv_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encStart = 1'b0;
  logic [15:0] encMult = '0;
  logic        encDone, encErr;
  logic [31:0] encWord;
  logic        decStart = 1'b0;
  logic [16:0] decCode = '0;
  logic        decDone;
  logic [15:0] decMult;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pll_mcode_conv uut (
    .clk(clk), .rstN(rstN),
    .encStart(encStart), .encMult(encMult), .encDone(encDone),
    .encErr(encErr), .encWord(encWord),
    .decStart(decStart), .decCode(decCode), .decDone(decDone),
    .decMult(decMult)
  );

  localparam int NV = 13;
  localparam bit VDEC [NV] = '{0,0,0,0,0,0,0,0,1,1,1,1,1};
  localparam logic [16:0] VIN [NV] = '{17'd0, 17'd1, 17'd2, 17'd32768,
    17'd32767, 17'd32756, 17'd32755, 17'd32754,
    17'h18003, 17'h10003, 17'h02000, 17'h04001, 17'h06000};
  localparam logic [31:0] VEXP [NV] = '{32'h01020000, 32'h01038003,
    32'h01050003, 32'h007E2000, 32'h007E1000, 32'h007E0002, 32'h007E4001,
    32'h007E6000, 32'd1, 32'd2, 32'd32768, 32'd32755, 32'd32754};
  localparam int VLAT [NV] = '{1, 1, 1, 2, 3, 14, 15, 16, 1, 1, 2, 15, 16};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] mdl_code(input int m);
    logic [16:0] x;
    if (m == 0) return 17'h00000;
    if (m == 1) return 17'h18003;
    if (m == 2) return 17'h10003;
    x = 17'h04000;
    for (int i = m; i <= 32768; i++) x = {2'b00, x[0] ^ x[1], x[14:1]};
    return x;
  endfunction

  function automatic logic [4:0] mdl_selp(input int m);
    return (m < 60) ? 5'((m >> 1) + 1) : 5'd31;
  endfunction

  function automatic logic [5:0] mdl_seli(input int m);
    if (m > 16384) return 6'd1;
    if (m > 8192)  return 6'd2;
    if (m > 2048)  return 6'd4;
    if (m >= 501)  return 6'd8;
    if (m >= 60)   return 6'(((1024 + m + 8) / (m + 9)) * 4);
    return 6'((m & 32'h3C) + 4);
  endfunction

  task automatic run_enc(input logic [15:0] m, output logic [31:0] w, output int lat);
    @(negedge clk); encMult = m; encStart = 1'b1;
    @(negedge clk); encStart = 1'b0; lat = 0;
    while (!encDone && lat < 40000) begin @(negedge clk); lat++; end
    w = encWord;
  endtask

  task automatic run_dec(input logic [16:0] c, output logic [15:0] r, output int lat);
    @(negedge clk); decCode = c; decStart = 1'b1;
    @(negedge clk); decStart = 1'b0; lat = 0;
    while (!decDone && lat < 40000) begin @(negedge clk); lat++; end
    r = decMult;
  endtask

  task automatic enc_model_check(input int m);
    logic [31:0] w; int lat;
    run_enc(16'(m), w, lat);
    check("R2 code", 64'(w[16:0]), 64'(mdl_code(m)));
    check("R3 proportional", 64'(w[21:17]), 64'(mdl_selp(m)));
    check("R4 integral", 64'(w[27:22]), 64'(mdl_seli(m)));
    check("R5 pad", 64'(w[31:28]), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 195000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] w; logic [15:0] r; int lat; int ndec; logic [31:0] wPrev; logic [15:0] rPrev;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 encDone", 64'(encDone), 64'd0);
    check("R11 decDone", 64'(decDone), 64'd0);
    check("R11 encErr", 64'(encErr), 64'd0);
    check("R11 encWord", 64'(encWord), 64'd0);
    check("R11 decMult", 64'(decMult), 64'd0);

    // table: R1 R2 R3 R5 encodes, R6 R7 decodes, R12 latency
    for (int i = 0; i < NV; i++) begin
      if (VDEC[i]) begin
        run_dec(VIN[i], r, lat);
        check(i < 10 ? "R6 decode" : "R7 decode", 64'(r), 64'(VEXP[i]));
      end else begin
        run_enc(VIN[i][15:0], w, lat);
        check(i < 3 ? "R1 encode" : "R2 encode", 64'(w), 64'(VEXP[i]));
      end
      check("R12 latency", 64'(lat), 64'(VLAT[i]));
    end

    // R12 done lasts one cycle
    run_enc(16'd1, w, lat);
    @(negedge clk);
    check("R12 pulse width", 64'(encDone), 64'd0);

    // R3 R4 each integral band, exact divisor at 119
    enc_model_check(20000);
    enc_model_check(12000);
    enc_model_check(3000);
    enc_model_check(119);
    check("R4 exact ceiling", 64'(encWord[27:22]), 64'd32);
    enc_model_check(40);

    // R7 round trip and output frequency
    run_enc(16'd32700, w, lat);
    run_dec(w[16:0], r, lat);
    check("R7 round trip", 64'(r), 64'd32700);
    check("R7 frequency", 64'(r) * 2 * 64'd12000000, 64'd2 * 64'd32700 * 64'd12000000);

    // R8 invalid code
    run_dec(17'h00000, r, lat);
    check("R8 invalid", 64'(r), 64'd0);

    // R9 overrange
    wPrev = encWord;
    @(negedge clk); encMult = 16'd32769; encStart = 1'b1;
    @(negedge clk); encStart = 1'b0;
    check("R9 err raised", 64'(encErr), 64'd1);
    ndec = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (encDone) ndec++;
      if (k == 0) check("R9 err one cycle", 64'(encErr), 64'd0);
    end
    check("R9 no done", 64'(ndec), 64'd0);
    check("R9 word kept", 64'(encWord), 64'(wPrev));

    // R10 start during a running encode is ignored
    rPrev = decMult;
    @(negedge clk); encMult = 16'd32760; encStart = 1'b1;
    @(negedge clk); encStart = 1'b0; decCode = 17'h18003; decStart = 1'b1;
    @(negedge clk); decStart = 1'b0;
    ndec = 0; lat = 0;
    while (!encDone && lat < 100) begin if (decDone) ndec++; @(negedge clk); lat++; end
    check("R10 busy encode word", 64'(encWord), {32'd0, 32'h007E0020});
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (decDone) ndec++; end
    check("R10 busy no decode", 64'(ndec), 64'd0);
    check("R10 busy decMult kept", 64'(decMult), 64'(rPrev));

    // R10 simultaneous starts: encode wins
    @(negedge clk); encMult = 16'd2; encStart = 1'b1; decCode = 17'h18003; decStart = 1'b1;
    @(negedge clk); encStart = 1'b0; decStart = 1'b0;
    ndec = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (decDone) ndec++; end
    check("R10 tie encode word", 64'(encWord), 64'h01050003);
    check("R10 tie no decode", 64'(ndec), 64'd0);
    check("R10 tie decMult kept", 64'(decMult), 64'(rPrev));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule